// File: doc/BRIEF.md
# Split-Access 64-bit Register Bank

This block is a bank of 64-bit registers that a 32-bit bus can reach. Each register takes two consecutive word addresses. A write to the even word only stages the upper half. The register changes only when the odd word is written. At that point the staged upper half and the new lower half are committed together. A read of the even word captures the odd word at the same moment, so a counter that keeps running still reads back as one coherent 64-bit value across the two bus reads.

The bank holds a master configuration register and seven free-running event counters. The configuration register carries a software reset bit. Writing that bit as 1 produces a one-cycle pulse on an output port, and the bit always reads back as 0. Three counters count requests, one per strobe. Four counters accumulate byte counts of 0 to 255 per strobe. All counters wrap modulo 2^64. Read data is registered and appears one cycle after the read request.

A two-state capture machine governs the reads. Its states are `SNAP_IDLE` (no capture pending) and `SNAP_HELD` (a lower half is frozen for one register). It has these transitions:
- capture: `SNAP_IDLE` to `SNAP_HELD`, on an in-range even-word read.
- recapture: `SNAP_HELD` to `SNAP_HELD`, on another in-range even-word read.
- release: `SNAP_HELD` to `SNAP_IDLE`, on any in-range odd-word read.
- hold: the state stays as it is on any other cycle.

Top module: `split_reg_bank`

## Requirements
- R1: After a synchronous reset, the following are all zero: the configuration register, every counter, the staging register, the capture state and `rdata`. `sw_rst_pulse` is low.
- R2: The address is decoded as follows.
  - Register index = `addr[4:1]`. Index 0 is the configuration register.
  - Indices 1 to 3 are the request counters: dequeued, outbound encrypt and inbound decrypt.
  - Indices 4 to 7 are the byte counters: outbound encrypted, outbound protected, inbound decrypted and inbound validated.
  - `addr[0]`=0 selects bits 63:32 and `addr[0]`=1 selects bits 31:0.
  - `rdata` carries the selected word in the cycle after `rd_en`, and is zero in the cycle after any cycle without `rd_en`.
- R3: A write to word address 0 loads only the staging register. The configuration register keeps its value.
- R4: A write to word address 1 commits {staging, `wdata`} to the configuration register. The staging register keeps its contents, so a lone write to address 1 after reset acts as a 32-bit write of the low half.
- R5: A committed write with `wdata[31]`=1 raises `sw_rst_pulse` for exactly the one cycle after the write. Bit 31 reads back as 0, and all other configuration bits read back as written.
- R6: Request counter k (bit k of `req_strobe`) increases by one in each cycle in which its strobe is high.
- R7: Byte counter j (bit j of `byte_strobe`) adds `byte_count[8j+7:8j]` in each cycle in which its strobe is high.
- R8: An even-word read of an in-range register captures that register's bits 31:0 in the same cycle. The next odd-word read of the same register returns the captured value, even if the counter has since moved on.
- R9: An odd-word read returns the live value when no capture is held for that register. Any in-range odd-word read ends a held capture.
- R10: Writes to counter addresses have no effect on any counter or on the staging register.
- R11: Word addresses 16 to 31 read as zero. Writes to them have no effect, and reads of them leave the capture untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for `addr` |
| rd_en | input | 1 | Read request for `addr` |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| req_strobe | input | 3 | Increment strobes for the request counters |
| byte_strobe | input | 4 | Accumulate strobes for the byte counters |
| byte_count | input | 32 | Four 8-bit byte counts, lane j in bits 8j+7:8j |
| sw_rst_pulse | output | 1 | One-cycle software reset pulse |

## Verification
A wrong capture state can only be seen on the odd-word read that follows an even-word read. If the capture is lost, that read returns the live low half instead of the frozen one. If a capture is stuck, a later unrelated odd-word read returns a stale value. Either error shows up in `rdata` one cycle after the faulty read. A staging or commit fault shows up as a wrong configuration readback one cycle after the next read of that register. A counter fault shows up on any later read of that counter, because the counters hold their state for good. The bench therefore reads every register often, while the strobes keep the counters running between the two halves of each read.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int REG_W  = 64;
    localparam int HALF_W = REG_W / 2;
    localparam int N_REQ  = 3;
    localparam int N_BYTE = 4;
    localparam int BCNT_W = 8;
    localparam int N_CNT  = N_REQ + N_BYTE;
    localparam int N_REG  = 1 + N_CNT;
    localparam int IDX_W  = $clog2(N_REG);

    typedef enum logic {
        SNAP_IDLE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_t;
endpackage

// File: rtl/srb_counters.sv
module srb_counters
    import srb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_REQ-1:0]          req_strobe,
    input  logic [N_BYTE-1:0]         byte_strobe,
    input  logic [N_BYTE*BCNT_W-1:0]  byte_count,
    output logic [N_CNT*REG_W-1:0]    cnt_flat
);
    // request counters occupy the low slots, byte counters follow
    for (genvar k = 0; k < N_REQ; k++) begin : g_req
        logic [REG_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= '0;
            else if (req_strobe[k])
                val_q <= val_q + REG_W'(1);
        end
        assign cnt_flat[k*REG_W +: REG_W] = val_q;
    end

    for (genvar j = 0; j < N_BYTE; j++) begin : g_byte
        logic [REG_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= '0;
            else if (byte_strobe[j])
                val_q <= val_q + REG_W'(byte_count[j*BCNT_W +: BCNT_W]);
        end
        assign cnt_flat[(N_REQ+j)*REG_W +: REG_W] = val_q;
    end
endmodule

// File: rtl/srb_cfg_reg.sv
module srb_cfg_reg
    import srb_pkg::*;
#(
    parameter int RST_BIT = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stage_we,
    input  logic              commit_we,
    input  logic [HALF_W-1:0] wdata,
    output logic [REG_W-1:0]  cfg_q,
    output logic              sw_rst_pulse
);
    localparam logic [HALF_W-1:0] KEEP_MASK = ~(HALF_W'(1) << RST_BIT);

    logic [HALF_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else if (stage_we)
            stage_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q        <= '0;
            sw_rst_pulse <= 1'b0;
        end else begin
            sw_rst_pulse <= commit_we && wdata[RST_BIT];
            if (commit_we)
                cfg_q <= {stage_q, wdata & KEEP_MASK};
        end
    end
endmodule

// File: rtl/srb_snap_fsm.sv
module srb_snap_fsm
    import srb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_upper,
    input  logic              rd_lower,
    input  logic [IDX_W-1:0]  idx,
    input  logic [HALF_W-1:0] live_low,
    output logic [HALF_W-1:0] low_word
);
    snap_state_t       state_q, state_nx;
    logic [HALF_W-1:0] snap_q;
    logic [IDX_W-1:0]  snap_idx_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SNAP_IDLE;
        else
            state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q     <= '0;
            snap_idx_q <= '0;
        end else if (rd_upper) begin
            snap_q     <= live_low;
            snap_idx_q <= idx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SNAP_IDLE: if (rd_upper) state_nx = SNAP_HELD;
            SNAP_HELD: begin
                if (rd_upper)      state_nx = SNAP_HELD;
                else if (rd_lower) state_nx = SNAP_IDLE;
            end
            default: state_nx = SNAP_IDLE;
        endcase
    end

    always_comb begin
        if (state_q == SNAP_HELD && snap_idx_q == idx)
            low_word = snap_q;
        else
            low_word = live_low;
    end
endmodule

// File: rtl/split_reg_bank.sv
module split_reg_bank
    import srb_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [HALF_W-1:0]         wdata,
    output logic [HALF_W-1:0]         rdata,
    input  logic [N_REQ-1:0]          req_strobe,
    input  logic [N_BYTE-1:0]         byte_strobe,
    input  logic [N_BYTE*BCNT_W-1:0]  byte_count,
    output logic                      sw_rst_pulse
);
    localparam int FIDX_W = ADDR_W - 1;

    logic [FIDX_W-1:0]     idx_full;
    logic [IDX_W-1:0]      idx;
    logic                  in_range;
    logic                  low_sel;
    logic [REG_W-1:0]      cfg_q;
    logic [N_CNT*REG_W-1:0] cnt_flat;
    logic [REG_W-1:0]      live [N_REG];
    logic [REG_W-1:0]      live_sel;
    logic [HALF_W-1:0]     low_word;
    logic                  rd_upper, rd_lower;

    assign idx_full = addr[ADDR_W-1:1];
    assign idx      = idx_full[IDX_W-1:0];
    assign in_range = idx_full < FIDX_W'(N_REG);
    assign low_sel  = addr[0];
    assign rd_upper = rd_en && in_range && !low_sel;
    assign rd_lower = rd_en && in_range && low_sel;

    srb_cfg_reg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .stage_we     (wr_en && in_range && idx == '0 && !low_sel),
        .commit_we    (wr_en && in_range && idx == '0 && low_sel),
        .wdata        (wdata),
        .cfg_q        (cfg_q),
        .sw_rst_pulse (sw_rst_pulse)
    );

    srb_counters u_cnt (
        .clk         (clk),
        .rst         (rst),
        .req_strobe  (req_strobe),
        .byte_strobe (byte_strobe),
        .byte_count  (byte_count),
        .cnt_flat    (cnt_flat)
    );

    always_comb begin
        live[0] = cfg_q;
        for (int k = 0; k < N_CNT; k++)
            live[k+1] = cnt_flat[k*REG_W +: REG_W];
    end

    assign live_sel = in_range ? live[idx] : '0;

    srb_snap_fsm u_snap (
        .clk      (clk),
        .rst      (rst),
        .rd_upper (rd_upper),
        .rd_lower (rd_lower),
        .idx      (idx),
        .live_low (live_sel[HALF_W-1:0]),
        .low_word (low_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_upper)
            rdata <= live_sel[REG_W-1:HALF_W];
        else if (rd_lower)
            rdata <= low_word;
        else
            rdata <= '0;
    end
endmodule

// File: rtl/srb_checker.sv
module srb_checker
    import srb_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [HALF_W-1:0]         wdata,
    input logic [HALF_W-1:0]         rdata,
    input logic [N_REQ-1:0]          req_strobe,
    input logic [N_BYTE-1:0]         byte_strobe,
    input logic                      sw_rst_pulse,
    input logic [REG_W-1:0]          cfg_q,
    input logic [N_CNT*REG_W-1:0]    cnt_flat
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rdata == '0 && !sw_rst_pulse && cfg_q == '0 && cnt_flat == '0));

    // R2
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> rdata == '0);

    // R3
    stage_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(0)) |=> $stable(cfg_q));

    // R5
    pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        sw_rst_pulse |-> $past(wr_en && addr == ADDR_W'(1) && wdata[31]));

    // R6
    req_inc_chk: assert property (@(posedge clk) disable iff (rst)
        req_strobe[0] |=> cnt_flat[REG_W-1:0] == $past(cnt_flat[REG_W-1:0]) + REG_W'(1));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_strobe == '0 && byte_strobe == '0) |=> $stable(cnt_flat));
endmodule

bind split_reg_bank srb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .req_strobe   (req_strobe),
    .byte_strobe  (byte_strobe),
    .sw_rst_pulse (sw_rst_pulse),
    .cfg_q        (cfg_q),
    .cnt_flat     (cnt_flat)
);

// File: tb/tb_split_reg_bank.sv
module tb_split_reg_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  req_strobe = '0;
    logic [3:0]  byte_strobe = '0;
    logic [31:0] byte_count = '0;
    logic        sw_rst_pulse;

    always #2 clk = ~clk;

    split_reg_bank dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_strobe(req_strobe),
        .byte_strobe(byte_strobe), .byte_count(byte_count),
        .sw_rst_pulse(sw_rst_pulse)
    );

    // behavioural reference
    logic [63:0] m_cfg;
    logic [31:0] m_stage;
    logic [63:0] m_cnt [0:6];
    bit          m_held;
    int          m_hidx;
    logic [31:0] m_snap;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic model_reset();
        m_cfg = '0; m_stage = '0; m_held = 0; m_hidx = 0; m_snap = '0;
        for (int k = 0; k < 7; k++) m_cnt[k] = '0;
    endtask

    function automatic logic [63:0] m_live(int i);
        return (i == 0) ? m_cfg : m_cnt[i-1];
    endfunction

    task automatic step(input bit w, input bit r, input logic [4:0] a,
                        input logic [31:0] d, input logic [2:0] rs,
                        input logic [3:0] bs, input logic [31:0] bc,
                        input string req);
        logic [31:0] exp_rd;
        bit          exp_pulse;
        int          i;
        bit          lo;
        wr_en = w; rd_en = r; addr = a; wdata = d;
        req_strobe = rs; byte_strobe = bs; byte_count = bc;
        i = int'(a >> 1);
        lo = a[0];
        exp_rd = '0;
        exp_pulse = 0;
        if (r && i < 8) begin
            if (!lo) begin
                exp_rd = m_live(i)[63:32];
                m_held = 1; m_hidx = i; m_snap = m_live(i)[31:0];
            end else begin
                exp_rd = (m_held && m_hidx == i) ? m_snap : m_live(i)[31:0];
                m_held = 0;
            end
        end
        if (w && i == 0) begin
            if (!lo) m_stage = d;
            else begin
                m_cfg = {m_stage, d & 32'h7fff_ffff};
                exp_pulse = d[31];
            end
        end
        for (int k = 0; k < 3; k++) if (rs[k]) m_cnt[k] = m_cnt[k] + 64'd1;
        for (int j = 0; j < 4; j++) if (bs[j]) m_cnt[3+j] = m_cnt[3+j] + 64'(bc[j*8 +: 8]);
        @(negedge clk);
        checks++;
        if (rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", req, a, rdata, exp_rd);
        end
        checks++;
        if (sw_rst_pulse !== exp_pulse) begin
            errors++;
            $display("FAIL R5 sw_rst_pulse actual=%b expected=%b", sw_rst_pulse, exp_pulse);
        end
    endtask

    task automatic rd(input logic [4:0] a, input string req);
        step(0, 1, a, '0, '0, '0, '0, req);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string req);
        step(1, 0, a, d, '0, '0, '0, req);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        checks++;
        if (rdata !== '0 || sw_rst_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset actual=%h/%b expected=0/0", rdata, sw_rst_pulse);
        end
        rst = 1'b0;

        // R1 / R11: everything reads zero, reserved range included
        for (int a = 0; a < 32; a++) rd(5'(a), (a < 16) ? "R1" : "R11");

        // R4: lone low-word write with empty staging
        wr(5'd1, 32'h0000_0055, "R4");
        rd(5'd0, "R4"); rd(5'd1, "R4");
        // R3: staging write leaves the register alone
        wr(5'd0, 32'h1234_5678, "R3");
        rd(5'd0, "R3"); rd(5'd1, "R3");
        // R4: commit with staged upper half
        wr(5'd1, 32'h0000_abcd, "R4");
        rd(5'd0, "R4"); rd(5'd1, "R4");
        // R4: staging kept after commit
        wr(5'd1, 32'h0f0f_0f0f, "R4");
        rd(5'd0, "R4"); rd(5'd1, "R4");
        // R5: software reset bit pulses and reads back as zero
        wr(5'd1, 32'h8000_0011, "R5");
        step(0, 0, '0, '0, '0, '0, '0, "R5");
        rd(5'd1, "R5"); rd(5'd0, "R5");
        wr(5'd1, 32'hffff_ffff, "R5");
        rd(5'd1, "R5");

        // R6 / R7: counting with varied strobe patterns
        for (int n = 0; n < 40; n++)
            step(0, 0, '0, '0, 3'(n), 4'(n >> 1), 32'h11ff_80_01 + 32'(n), "R6");
        for (int k = 1; k < 8; k++) begin
            rd(5'(2*k), (k < 4) ? "R6" : "R7");
            rd(5'(2*k+1), (k < 4) ? "R6" : "R7");
        end

        // R8: capture survives counting between halves
        step(0, 1, 5'd8, '0, 3'b111, 4'b1111, 32'hc8c8_c8c8, "R8");
        for (int n = 0; n < 5; n++) step(0, 0, '0, '0, 3'b111, 4'b1111, 32'hc8c8_c8c8, "R8");
        step(0, 1, 5'd9, '0, 3'b111, 4'b1111, 32'hc8c8_c8c8, "R8");
        // R9: second low read is live; other register's low read is live
        step(0, 1, 5'd9, '0, '0, 4'b0001, 32'h0000_0007, "R9");
        rd(5'd2, "R9");
        step(0, 1, 5'd11, '0, 3'b001, 4'b0010, 32'h0000_0900, "R9");
        step(0, 1, 5'd3, '0, 3'b001, '0, '0, "R9");
        // R11: reserved reads leave the capture alone
        step(0, 1, 5'd14, '0, '0, 4'b1000, 32'h5000_0000, "R11");
        rd(5'd20, "R11");
        step(0, 1, 5'd15, '0, '0, 4'b1000, 32'h5000_0000, "R11");

        // R10 / R11: ignored writes
        for (int k = 2; k < 16; k++) wr(5'(k), 32'hdead_beef, "R10");
        for (int k = 16; k < 32; k++) wr(5'(k), 32'hfeed_f00d, "R11");
        wr(5'd1, 32'h0000_0001, "R10");
        rd(5'd0, "R10"); rd(5'd1, "R10");
        for (int k = 2; k < 16; k++) rd(5'(k), "R10");

        // R2: mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r0;
            r0 = $urandom;
            step(r0[0] & r0[1], r0[2], 5'(r0[7:3] & ((r0[8]) ? 5'h1f : 5'h0f)),
                 $urandom, r0[11:9], r0[15:12], $urandom, "R2");
        end

        summary();
        $finish;
    end
endmodule